// File: doc/BRIEF.md
# Serial Register-File Target with Time Snapshot

This block is a standard-mode two-wire bus target that gives a host access to a 64-byte address space through one auto-incrementing pointer. It oversamples the serial clock and data lines with the chip's fast system clock, recognises bus START, repeated START and STOP conditions, and answers only to the fixed 7-bit address 1101000. It acknowledges and returns read data by pulling the data line low through an output-enable, so the line stays open-drain.

The lower eight locations belong to an external timekeeper. On every START the block copies the timekeeper's live byte vector into a shadow buffer, and reads of those locations come from that copy while the clock keeps counting. Writes to those locations leave the block as one-cycle strobes carrying the address and the data. The remaining 56 locations are RAM held inside the block. A power-fail input abandons any transfer and clears the pointer. While that input is high the block ignores the bus.

Top module: `i2cRegFile`

## Requirements
- R1: The first byte after a START is the 7-bit address followed by a direction bit (0 = write, 1 = read), MSB first. When the address is 1101000 the block holds SDA low (sdaOe = 1) through the ninth SCL clock.
- R2: A first byte carrying any other address gets no acknowledge. The block then leaves SDA alone and stores nothing until the next START.
- R3: In a write, the first byte after the address sets the pointer to its low six bits. Each further byte is stored at the pointer, and the pointer then advances by one.
- R4: A read starts at the current pointer, which is either set by an earlier write or left where the last access stopped. The pointer advances by one after each byte sent.
- R5: The pointer advances from 3Fh to 00h, in both reads and writes.
- R6: Every START, repeated ones included, copies liveTime into the shadow buffer. Byte k of liveTime is bits 8k+7..8k. Reads of locations 00h..07h return the copy, so later changes of liveTime are not visible until the next START.
- R7: A write to a location 00h..07h is not stored inside the block. It produces a single-cycle clkWrEn pulse with clkWrAddr and clkWrData, issued when the block acknowledges that byte. Locations 08h..3Fh are stored in internal RAM.
- R8: When the host answers a read byte with NACK (SDA high on the ninth clock), the block releases SDA and sends no further bytes.
- R9: While powerFail is high the block releases SDA (sdaOe = 0 from the next cycle) and sets the pointer to 00h. It acknowledges nothing and stores nothing.
- R10: SDA falling while SCL is high is a START, and SDA rising while SCL is high is a STOP. After a STOP the block ignores bus traffic until a START. The block changes sdaOe only while SCL is low.
- R11: After reset sdaOe and clkWrEn are 0, the pointer is 00h and all RAM bytes are 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rstN | input | 1 | Asynchronous active-low reset |
| powerFail | input | 1 | Supply-failure indication, synchronous to clk |
| sclIn | input | 1 | Serial clock line as seen on the pad |
| sdaIn | input | 1 | Serial data line as seen on the pad |
| sdaOe | output | 1 | 1 pulls the data line low, 0 releases it |
| liveTime | input | 64 | Running timekeeper bytes, byte k in bits 8k+7..8k |
| clkWrEn | output | 1 | One-cycle strobe for a write to a timekeeper location |
| clkWrAddr | output | 3 | Timekeeper location being written |
| clkWrData | output | 8 | Byte written to the timekeeper |

## Verification
Some properties are checked on every cycle by assertions. sdaOe may rise only while the sampled SCL is low, and it drops right after powerFail. The pointer returns to zero after a wrap or a power-fail clear. The shadow buffer holds the liveTime value present at the START, and each timekeeper strobe follows a committed byte. Other behaviour shows only in the bench's bus scenarios:
- the address filter, including refusal and silence on a foreign address;
- the pointer surviving from one transaction into the next;
- the repeated-START snapshot seen against liveTime changing in the middle of a transfer;
- RAM contents left untouched by traffic during power-fail or after a STOP.

// File: rtl/i2cRegPkg.sv
package i2cRegPkg;

  // Strobes from the bus controller to the datapath, valid for one clk cycle
  typedef struct packed {
    logic snap;      // copy liveTime into the shadow buffer
    logic rxShift;   // shift rxBit into the receive register
    logic rxBit;     // sampled data bit
    logic ptrLoad;   // load pointer from the received byte
    logic wrCommit;  // store the received byte at the pointer, then advance
    logic txLoad;    // load the transmit register from the pointer location
    logic txShift;   // move to the next transmit bit
    logic ptrInc;    // advance the pointer after a sent byte
    logic ptrClear;  // force the pointer to zero
  } strobeT;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_RX,
    ST_RX_ACK,
    ST_TX,
    ST_TX_ACK
  } busStateT;

endpackage

// File: rtl/i2cRegCtrl.sv
module i2cRegCtrl
  import i2cRegPkg::*;
#(
  parameter int DW = 8,
  parameter int SYNC = 2,
  parameter logic [DW-2:0] DEV_ADDR = 7'b1101000
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          powerFail,
  input  logic          sclIn,
  input  logic          sdaIn,
  input  logic [DW-1:0] rxByte,
  input  logic          txBit,
  output strobeT        stb,
  output logic          sdaOe
);

  localparam int CNT_W = $clog2(DW + 1);
  localparam logic [CNT_W-1:0] BYTE_END = CNT_W'(DW);

  // Line synchronisers; lines idle high
  logic [SYNC-1:0] sclPipe, sdaPipe;
  logic sclS, sdaS, sclPrev, sdaPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[SYNC-2:0], sclIn};
      sdaPipe <= {sdaPipe[SYNC-2:0], sdaIn};
      sclPrev <= sclS;
      sdaPrev <= sdaS;
    end
  end

  assign sclS = sclPipe[SYNC-1];
  assign sdaS = sdaPipe[SYNC-1];

  logic sclRise, sclFall, startEv, stopEv;
  assign sclRise = sclS & ~sclPrev;
  assign sclFall = ~sclS & sclPrev;
  assign startEv = sclS & sclPrev & sdaPrev & ~sdaS;
  assign stopEv  = sclS & sclPrev & ~sdaPrev & sdaS;

  busStateT state, stateNx;
  logic [CNT_W-1:0] cnt, cntNx;
  logic rw, rwNx, first, firstNx, hostAck, hostAckNx;

  always_comb begin
    stateNx   = state;
    cntNx     = cnt;
    rwNx      = rw;
    firstNx   = first;
    hostAckNx = hostAck;
    stb       = '0;
    if (powerFail) begin
      stateNx      = ST_IDLE;
      cntNx        = '0;
      stb.ptrClear = 1'b1;
    end else if (startEv) begin
      stateNx  = ST_ADDR;
      cntNx    = '0;
      stb.snap = 1'b1;
    end else if (stopEv) begin
      stateNx = ST_IDLE;
    end else begin
      unique case (state)
        ST_ADDR, ST_RX: begin
          if (sclRise && cnt < BYTE_END) begin
            stb.rxShift = 1'b1;
            stb.rxBit   = sdaS;
            cntNx       = cnt + 1'b1;
          end else if (sclFall && cnt == BYTE_END) begin
            if (state == ST_ADDR) begin
              if (rxByte[DW-1:1] == DEV_ADDR) begin
                stateNx = ST_ADDR_ACK;
                rwNx    = rxByte[0];
              end else begin
                stateNx = ST_IDLE;
              end
            end else begin
              stateNx = ST_RX_ACK;
              if (first) begin
                stb.ptrLoad = 1'b1;
                firstNx     = 1'b0;
              end else begin
                stb.wrCommit = 1'b1;
              end
            end
          end
        end
        ST_ADDR_ACK: begin
          if (sclFall) begin
            cntNx = '0;
            if (rw) begin
              stateNx    = ST_TX;
              stb.txLoad = 1'b1;
            end else begin
              stateNx = ST_RX;
              firstNx = 1'b1;
            end
          end
        end
        ST_RX_ACK: begin
          if (sclFall) begin
            stateNx = ST_RX;
            cntNx   = '0;
          end
        end
        ST_TX: begin
          if (sclRise && cnt < BYTE_END) begin
            cntNx = cnt + 1'b1;
          end else if (sclFall && cnt == BYTE_END) begin
            stateNx    = ST_TX_ACK;
            stb.ptrInc = 1'b1;
          end else if (sclFall && cnt != '0) begin
            stb.txShift = 1'b1;
          end
        end
        ST_TX_ACK: begin
          if (sclRise) begin
            hostAckNx = ~sdaS;
          end else if (sclFall) begin
            if (hostAck) begin
              stateNx    = ST_TX;
              stb.txLoad = 1'b1;
              cntNx      = '0;
            end else begin
              stateNx = ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      rw      <= 1'b0;
      first   <= 1'b0;
      hostAck <= 1'b0;
    end else begin
      state   <= stateNx;
      cnt     <= cntNx;
      rw      <= rwNx;
      first   <= firstNx;
      hostAck <= hostAckNx;
    end
  end

  assign sdaOe = (state == ST_ADDR_ACK) || (state == ST_RX_ACK) ||
                 ((state == ST_TX) && !txBit);

  // R9: power-fail releases the data line on the next cycle
  assert_pf_release_R9: assert property (@(posedge clk) disable iff (!rstN)
    powerFail |=> !sdaOe);

  // R10: the target starts pulling SDA low only while SCL is low
  assert_oe_rise_scl_low_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaOe) |-> !sclPrev);

endmodule

// File: rtl/i2cRegData.sv
module i2cRegData
  import i2cRegPkg::*;
#(
  parameter int DW = 8,
  parameter int SPACE = 64,
  parameter int CLK_REGS = 8
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  strobeT                      stb,
  input  logic [CLK_REGS*DW-1:0]      liveTime,
  output logic [DW-1:0]               rxByte,
  output logic                        txBit,
  output logic                        clkWrEn,
  output logic [$clog2(CLK_REGS)-1:0] clkWrAddr,
  output logic [DW-1:0]               clkWrData
);

  localparam int PTR_W  = $clog2(SPACE);
  localparam int CA_W   = $clog2(CLK_REGS);
  localparam int RAM_N  = SPACE - CLK_REGS;
  localparam int RA_W   = $clog2(RAM_N);
  localparam int TIME_W = CLK_REGS * DW;
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(SPACE - 1);
  localparam logic [PTR_W-1:0] RAM_BASE = PTR_W'(CLK_REGS);

  logic [PTR_W-1:0] ptr, nextPtr;
  logic [DW-1:0]    rxSh, txSh, rdByte;
  logic [DW-1:0]    shadow [CLK_REGS];
  logic [DW-1:0]    ram [RAM_N];
  logic             inRam;
  logic [RA_W-1:0]  ramIdx;

  assign inRam   = ptr >= RAM_BASE;
  assign ramIdx  = RA_W'(ptr - RAM_BASE);
  assign nextPtr = (ptr == PTR_LAST) ? '0 : ptr + PTR_W'(1);
  assign rdByte  = inRam ? ram[ramIdx] : shadow[ptr[CA_W-1:0]];
  assign rxByte  = rxSh;
  assign txBit   = txSh[DW-1];

  // Snapshot of the timekeeper, one register per location
  for (genvar k = 0; k < CLK_REGS; k++) begin : gShadow
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)         shadow[k] <= '0;
      else if (stb.snap) shadow[k] <= liveTime[k*DW +: DW];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxSh <= '0;
      txSh <= '1;
    end else begin
      if (stb.rxShift) rxSh <= {rxSh[DW-2:0], stb.rxBit};
      if (stb.txLoad)       txSh <= rdByte;
      else if (stb.txShift) txSh <= {txSh[DW-2:0], 1'b1};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                             ptr <= '0;
    else if (stb.ptrClear)                 ptr <= '0;
    else if (stb.ptrLoad)                  ptr <= rxSh[PTR_W-1:0];
    else if (stb.wrCommit || stb.ptrInc)   ptr <= nextPtr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < RAM_N; i++) ram[i] <= '0;
    end else if (stb.wrCommit && inRam) begin
      ram[ramIdx] <= rxSh;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkWrEn   <= 1'b0;
      clkWrAddr <= '0;
      clkWrData <= '0;
    end else begin
      clkWrEn <= stb.wrCommit && !inRam;
      if (stb.wrCommit && !inRam) begin
        clkWrAddr <= ptr[CA_W-1:0];
        clkWrData <= rxSh;
      end
    end
  end

  // R5: advancing from the last location lands on zero
  assert_ptr_wrap_R5: assert property (@(posedge clk) disable iff (!rstN)
    (ptr == PTR_LAST && (stb.ptrInc || stb.wrCommit) && !stb.ptrClear && !stb.ptrLoad)
      |=> ptr == '0);

  // R9: a power-fail clear leaves the pointer at zero
  assert_ptr_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
    stb.ptrClear |=> ptr == '0);

  // R6: the shadow holds the liveTime value present at the START
  assert_snapshot_R6: assert property (@(posedge clk) disable iff (!rstN)
    stb.snap |=> (shadow[CLK_REGS-1] == $past(liveTime[TIME_W-1 -: DW]) &&
                  shadow[0] == $past(liveTime[DW-1:0])));

  // R7: every timekeeper strobe follows a committed byte
  assert_clkwr_commit_R7: assert property (@(posedge clk) disable iff (!rstN)
    clkWrEn |-> $past(stb.wrCommit));

endmodule

// File: rtl/i2cRegFile.sv
module i2cRegFile
  import i2cRegPkg::*;
#(
  parameter int DW = 8,
  parameter int SPACE = 64,
  parameter int CLK_REGS = 8,
  parameter int SYNC = 2,
  parameter logic [DW-2:0] DEV_ADDR = 7'b1101000
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        powerFail,
  input  logic                        sclIn,
  input  logic                        sdaIn,
  output logic                        sdaOe,
  input  logic [CLK_REGS*DW-1:0]      liveTime,
  output logic                        clkWrEn,
  output logic [$clog2(CLK_REGS)-1:0] clkWrAddr,
  output logic [DW-1:0]               clkWrData
);

  strobeT        stb;
  logic [DW-1:0] rxByte;
  logic          txBit;

  i2cRegCtrl #(.DW(DW), .SYNC(SYNC), .DEV_ADDR(DEV_ADDR)) i_ctrl (
    .clk(clk), .rstN(rstN), .powerFail(powerFail),
    .sclIn(sclIn), .sdaIn(sdaIn),
    .rxByte(rxByte), .txBit(txBit),
    .stb(stb), .sdaOe(sdaOe)
  );

  i2cRegData #(.DW(DW), .SPACE(SPACE), .CLK_REGS(CLK_REGS)) i_data (
    .clk(clk), .rstN(rstN), .stb(stb), .liveTime(liveTime),
    .rxByte(rxByte), .txBit(txBit),
    .clkWrEn(clkWrEn), .clkWrAddr(clkWrAddr), .clkWrData(clkWrData)
  );

endmodule

// File: tb/test_i2cRegFile.sv
`timescale 1ns/1ps
module test_i2cRegFile;

  localparam int Q = 12;
  localparam int WATCHDOG = 150000;
  localparam logic [7:0] AW = 8'hD0;
  localparam logic [7:0] AR = 8'hD1;
  // {pointer, data} pairs for RAM write/read-back
  localparam logic [15:0] VEC [8] = '{16'h085A, 16'h09A5, 16'h173C, 16'h22FF,
                                      16'h2B01, 16'h3080, 16'h3AC3, 16'h3F7E};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic powerFail = 1'b0;
  logic mScl = 1'b1, mSda = 1'b1;
  logic [63:0] liveTime = 64'h0706050403020155;
  logic sdaOe, clkWrEn, sdaLine;
  logic [2:0] clkWrAddr;
  logic [7:0] clkWrData;

  int checks = 0, errors = 0, wrCount = 0;
  logic [2:0] lastAddr = '0;
  logic [7:0] lastData = '0;
  logic [7:0] rdBuf [8];
  bit done = 1'b0;

  always #2.5 clk = ~clk;
  assign sdaLine = mSda & ~sdaOe;

  i2cRegFile i_i2cRegFile (
    .clk(clk), .rstN(rstN), .powerFail(powerFail),
    .sclIn(mScl), .sdaIn(sdaLine), .sdaOe(sdaOe),
    .liveTime(liveTime), .clkWrEn(clkWrEn),
    .clkWrAddr(clkWrAddr), .clkWrData(clkWrData)
  );

  always @(negedge clk) if (clkWrEn) begin
    wrCount++;
    lastAddr = clkWrAddr;
    lastData = clkWrData;
  end

  task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic q();
    repeat (Q) @(negedge clk);
  endtask

  task automatic busStart();
    mSda = 1'b1; q(); mScl = 1'b1; q(); mSda = 1'b0; q(); mScl = 1'b0; q();
  endtask

  task automatic busStop();
    mSda = 1'b0; q(); mScl = 1'b1; q(); mSda = 1'b1; q();
  endtask

  task automatic sendBits(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      mSda = b[i]; q(); mScl = 1'b1; q(); q(); mScl = 1'b0; q();
    end
  endtask

  task automatic sendByte(input logic [7:0] b, output bit ack);
    sendBits(b);
    mSda = 1'b1; q(); mScl = 1'b1; q(); ack = !sdaLine; q(); mScl = 1'b0; q();
  endtask

  task automatic readByte(input bit last, output logic [7:0] b);
    mSda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      q(); mScl = 1'b1; q(); b[i] = sdaLine; q(); mScl = 1'b0;
    end
    q(); mSda = last; q(); mScl = 1'b1; q(); q(); mScl = 1'b0; q();
  endtask

  task automatic writeSeq(input logic [7:0] p, input int n,
                          input logic [7:0] d0, input logic [7:0] d1, input logic [7:0] d2);
    logic [7:0] ds [3];
    bit a;
    ds = '{d0, d1, d2};
    busStart();
    sendByte(AW, a);  check(a, "R1 address ack", {7'd0, a}, 8'h01);
    sendByte(p, a);   check(a, "R3 pointer ack", {7'd0, a}, 8'h01);
    for (int i = 0; i < n; i++) begin
      sendByte(ds[i], a); check(a, "R3 data ack", {7'd0, a}, 8'h01);
    end
    busStop();
  endtask

  task automatic readAt(input logic [7:0] p, input int n);
    bit a;
    busStart();
    sendByte(AW, a); check(a, "R1 address ack", {7'd0, a}, 8'h01);
    sendByte(p, a);  check(a, "R3 pointer ack", {7'd0, a}, 8'h01);
    busStart();
    sendByte(AR, a); check(a, "R1 read address ack", {7'd0, a}, 8'h01);
    for (int i = 0; i < n; i++) readByte(i == n - 1, rdBuf[i]);
    busStop();
  endtask

  task automatic readCur(input int n);
    bit a;
    busStart();
    sendByte(AR, a); check(a, "R1 read address ack", {7'd0, a}, 8'h01);
    for (int i = 0; i < n; i++) readByte(i == n - 1, rdBuf[i]);
    busStop();
  endtask

  initial begin
    repeat (WATCHDOG) @(negedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R10 watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit a;
    logic [7:0] b;
    int w0;
    logic [63:0] tB, tC;

    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    // R11 reset state
    check(!sdaOe, "R11 sdaOe after reset", {7'd0, sdaOe}, 8'h00);
    check(!clkWrEn, "R11 clkWrEn after reset", {7'd0, clkWrEn}, 8'h00);
    readCur(1);
    check(rdBuf[0] == 8'h55, "R11 pointer zero after reset", rdBuf[0], 8'h55);

    // R2 foreign address: no ack, nothing stored
    busStart();
    sendByte(8'hA0, a); check(!a, "R2 foreign address ack", {7'd0, a}, 8'h00);
    sendByte(8'h10, a); check(!a, "R2 byte after foreign address", {7'd0, a}, 8'h00);
    sendByte(8'h99, a); check(!a, "R2 byte after foreign address", {7'd0, a}, 8'h00);
    busStop();
    readAt(8'h10, 1);
    check(rdBuf[0] == 8'h00, "R2 R11 RAM untouched", rdBuf[0], 8'h00);

    // R3 table of RAM write/read-back vectors
    foreach (VEC[i]) begin
      writeSeq(VEC[i][15:8], 1, VEC[i][7:0], 8'h00, 8'h00);
      readAt(VEC[i][15:8], 1);
      check(rdBuf[0] == VEC[i][7:0], "R3 RAM read-back", rdBuf[0], VEC[i][7:0]);
    end

    // R6 snapshot on START and on repeated START
    tB = 64'h1211100F0E0D0C0B;
    tC = 64'hF1E2D3C4B5A69788;
    liveTime = 64'h0706050403020155;
    busStart();
    sendByte(AW, a);    check(a, "R1 address ack", {7'd0, a}, 8'h01);
    sendByte(8'h00, a); check(a, "R3 pointer ack", {7'd0, a}, 8'h01);
    liveTime = tB;
    busStart();
    sendByte(AR, a);    check(a, "R1 read address ack", {7'd0, a}, 8'h01);
    liveTime = tC;
    for (int i = 0; i < 8; i++) readByte(i == 7, rdBuf[i]);
    busStop();
    for (int i = 0; i < 8; i++)
      check(rdBuf[i] == tB[8*i +: 8], "R6 repeated-START snapshot", rdBuf[i], tB[8*i +: 8]);
    readAt(8'h02, 1);
    check(rdBuf[0] == tC[23:16], "R6 new START snapshot", rdBuf[0], tC[23:16]);

    // R5 R7 wrap from 3Fh into the timekeeper space
    w0 = wrCount;
    writeSeq(8'h3E, 3, 8'h11, 8'h22, 8'h33);
    check(wrCount == w0 + 1, "R7 one timekeeper strobe", 8'(wrCount - w0), 8'h01);
    check(lastAddr == 3'd0, "R5 R7 strobe address after wrap", {5'd0, lastAddr}, 8'h00);
    check(lastData == 8'h33, "R7 strobe data", lastData, 8'h33);
    readAt(8'h3E, 3);
    check(rdBuf[0] == 8'h11, "R5 byte at 3Eh", rdBuf[0], 8'h11);
    check(rdBuf[1] == 8'h22, "R5 byte at 3Fh", rdBuf[1], 8'h22);
    check(rdBuf[2] == tC[7:0], "R5 R7 read wraps to snapshot", rdBuf[2], tC[7:0]);

    // R4 pointer carried across transactions
    writeSeq(8'h20, 3, 8'hA1, 8'hA2, 8'hA3);
    writeSeq(8'h20, 0, 8'h00, 8'h00, 8'h00);
    readCur(1);
    check(rdBuf[0] == 8'hA1, "R4 read from written pointer", rdBuf[0], 8'hA1);
    readCur(1);
    check(rdBuf[0] == 8'hA2, "R4 read continues", rdBuf[0], 8'hA2);

    // R8 NACK releases the line
    readAt(8'h21, 1);
    busStart();
    sendByte(AR, a); check(a, "R1 read address ack", {7'd0, a}, 8'h01);
    readByte(1'b1, b);
    check(b == 8'hA3, "R4 byte at 22h", b, 8'hA3);
    check(!sdaOe, "R8 released after NACK", {7'd0, sdaOe}, 8'h00);
    begin
      int lowSeen = 0;
      mSda = 1'b1;
      for (int i = 0; i < 9; i++) begin
        q(); mScl = 1'b1; q(); if (!sdaLine) lowSeen++; q(); mScl = 1'b0; q();
      end
      check(lowSeen == 0, "R8 no data after NACK", 8'(lowSeen), 8'h00);
    end
    busStop();

    // R10 STOP returns to idle; traffic without START is ignored
    writeSeq(8'h28, 0, 8'h00, 8'h00, 8'h00);
    q(); mScl = 1'b0; q();
    sendByte(8'h55, a); check(!a, "R10 no ack after STOP", {7'd0, a}, 8'h00);
    sendByte(8'h66, a); check(!a, "R10 no ack after STOP", {7'd0, a}, 8'h00);
    readCur(1);
    check(rdBuf[0] == 8'h00, "R10 nothing stored after STOP", rdBuf[0], 8'h00);

    // R9 power-fail during the address acknowledge
    writeSeq(8'h30, 0, 8'h00, 8'h00, 8'h00);
    busStart();
    sendBits(AW);
    mSda = 1'b1; q(); mScl = 1'b1; q();
    check(sdaOe, "R1 ack held in ninth clock", {7'd0, sdaOe}, 8'h01);
    powerFail = 1'b1;
    repeat (2) @(negedge clk);
    check(!sdaOe, "R9 release on power-fail", {7'd0, sdaOe}, 8'h00);
    q(); mScl = 1'b0; q();
    busStart();
    sendByte(AW, a);    check(!a, "R9 no ack during power-fail", {7'd0, a}, 8'h00);
    sendByte(8'h31, a); check(!a, "R9 no ack during power-fail", {7'd0, a}, 8'h00);
    sendByte(8'h77, a);
    busStop();
    powerFail = 1'b0;
    q();
    readCur(1);
    check(rdBuf[0] == tC[7:0], "R9 pointer cleared", rdBuf[0], tC[7:0]);
    readAt(8'h31, 1);
    check(rdBuf[0] == 8'h00, "R9 write ignored", rdBuf[0], 8'h00);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule